// File: doc/BRIEF.md
# Timer Interrupt Vector and Request Logic

This block sits beside a timer's capture/compare channels and its counter overflow flag. The flags and enables live elsewhere; this block only reads them. A source is pending when its flag and its enable are both high. From the pending sources the block drives two interrupt request lines and a vector code that names the most urgent source. Channel 0 has a request line of its own. Every other channel shares the second line with the overflow source.

Software services the shared line by reading or writing the vector register, which is signalled here by the one-cycle `vec_access` pulse. That access returns the code and clears the reported source. In the same cycle the block pulses the clear strobe of that source, and the flag storage applies it at the next edge. Channel 0 is not cleared through this path. Its flag is cleared when the interrupt controller acknowledges request line 0. A side-effect-free copy of the code, `vec_peek`, is available for debug.

All pins are plain level or strobe signals. There is no data stream, so there is no valid/ready handshake.

Top module: `tiv_vector_top`

## Requirements
- R1: A channel is pending only when both its flag and its enable are high. `vec_peek` reports the lowest-numbered pending channel i as code 2*i, and lower indices win.
- R2: When no channel is pending and the overflow flag and its enable are both high, `vec_peek` is 0x0A.
- R3: When nothing is pending, `vec_peek` is 0x00.
- R4: In a cycle with `vec_access` high, if the reported source is channel i with i >= 1, `ch_clear[i]` pulses in that same cycle. No other channel clear and no overflow clear is raised.
- R5: A vector access that reports channel 0 raises no clear strobe at all.
- R6: A vector access that reports the overflow source pulses `ovf_clear` in that cycle and no channel clear.
- R7: `vec_rdata` loads the code that was valid in the access cycle. It shows that code one clock edge later and keeps it until the next access.
- R8: `irq_ch0` is high exactly when channel 0 is pending.
- R9: `irq_shared` is high when the overflow source is pending or any channel numbered 1 or higher is pending.
- R10: An acknowledge with `ack_valid` high and `ack_line` = 0 pulses `ch_clear[0]` in that cycle.
- R11: An acknowledge with `ack_line` = 1 raises no clear strobe.
- R12: After reset `vec_rdata` is 0x00. With `vec_access` and `ack_valid` low, every clear strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_flag | input | NUM_CH | Channel flags, held in external storage |
| ch_enable | input | NUM_CH | Channel interrupt enables |
| ovf_flag | input | 1 | Counter overflow flag |
| ovf_enable | input | 1 | Counter overflow interrupt enable |
| vec_access | input | 1 | One-cycle pulse: vector register read or written |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_line | input | 1 | Line being acknowledged (0 or 1) |
| irq_ch0 | output | 1 | Request line for channel 0 |
| irq_shared | output | 1 | Shared request line for overflow and channels 1 and up |
| vec_rdata | output | 4 | Code returned by the last vector access |
| vec_peek | output | 4 | Live code with no side effects |
| ch_clear | output | NUM_CH | Per-channel flag clear strobes |
| ovf_clear | output | 1 | Overflow flag clear strobe |

## Verification
The request lines, `vec_peek` and all clear strobes are combinational, so they are due in the same cycle as the input change that causes them. The bench drives inputs on the falling edge and samples these outputs one nanosecond later, before the next rising edge. `vec_rdata` has one register stage, so it is due one rising edge after the access. The bench samples it just after that edge, and again a few cycles later to confirm that it holds. Expected codes come from the bench's own priority model, which builds them from the flag and enable patterns it drives.

// File: rtl/tiv_pkg.sv
package tiv_pkg;
  localparam int CODE_W   = 4;
  localparam int MAX_CH   = 7;
  localparam int IDX_W    = 3;
  typedef logic [CODE_W-1:0] vcode_t;
  localparam vcode_t CODE_NONE = 4'h0;
  localparam vcode_t CODE_OVF  = 4'hA;

  // Channel i is reported as the even code 2*i
  function automatic vcode_t chan_code(input logic [IDX_W-1:0] idx);
    return {idx, 1'b0};
  endfunction
endpackage

// File: rtl/tiv_prio_scan.sv
module tiv_prio_scan #(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0]          pend,
  output logic [NUM_CH-1:0]          sel,
  output logic                       any,
  output logic [tiv_pkg::IDX_W-1:0]  idx
);
  // seen[i] is high when some channel below i is pending
  logic [NUM_CH:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chain
    assign sel[i]    = pend[i] & ~seen[i];
    assign seen[i+1] = seen[i] | pend[i];
  end

  assign any = seen[NUM_CH];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (sel[i]) idx = idx | tiv_pkg::IDX_W'(i);
  end
endmodule

// File: rtl/tiv_req_lines.sv
module tiv_req_lines #(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0] pend,
  input  logic              ovf_pend,
  output logic              irq_ch0,
  output logic              irq_shared
);
  assign irq_ch0    = pend[0];
  assign irq_shared = ovf_pend | (|pend[NUM_CH-1:1]);
endmodule

// File: rtl/tiv_clear_ctl.sv
module tiv_clear_ctl #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_access,
  input  logic              ack_valid,
  input  logic              ack_line,
  input  logic [NUM_CH-1:0] sel,
  input  logic              any_ch,
  input  logic              ovf_pend,
  output logic [NUM_CH-1:0] ch_clear,
  output logic              ovf_clear
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
    if (i == 0) begin : g_ack
      // channel 0 is released only by the acknowledge of its own line
      assign ch_clear[i] = ack_valid & ~ack_line;
    end else begin : g_acc
      assign ch_clear[i] = vec_access & sel[i];
    end
  end

  assign ovf_clear = vec_access & ~any_ch & ovf_pend;

  assert_access_one_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_clear[NUM_CH-1:1], ovf_clear}));

  assert_ch0_not_by_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_access && !(ack_valid && !ack_line)) |-> !ch_clear[0]);

  assert_ovf_only_when_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clear |-> (ovf_pend && !any_ch && vec_access));

  assert_line1_ack_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_line && !vec_access) |-> (ch_clear == '0 && !ovf_clear));

  assert_idle_no_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_access && !ack_valid) |-> (ch_clear == '0 && !ovf_clear));
endmodule

// File: rtl/tiv_vector_top.sv
module tiv_vector_top #(
  parameter int NUM_CH = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CH-1:0]           ch_flag,
  input  logic [NUM_CH-1:0]           ch_enable,
  input  logic                        ovf_flag,
  input  logic                        ovf_enable,
  input  logic                        vec_access,
  input  logic                        ack_valid,
  input  logic                        ack_line,
  output logic                        irq_ch0,
  output logic                        irq_shared,
  output logic [tiv_pkg::CODE_W-1:0]  vec_rdata,
  output logic [tiv_pkg::CODE_W-1:0]  vec_peek,
  output logic [NUM_CH-1:0]           ch_clear,
  output logic                        ovf_clear
);
  import tiv_pkg::*;

  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] sel;
  logic              any_ch;
  logic [IDX_W-1:0]  idx;
  logic              ovf_pend;
  vcode_t            code_now;

  assign pend     = ch_flag & ch_enable;
  assign ovf_pend = ovf_flag & ovf_enable;

  tiv_prio_scan #(.NUM_CH(NUM_CH)) u_scan (
    .pend (pend),
    .sel  (sel),
    .any  (any_ch),
    .idx  (idx)
  );

  tiv_req_lines #(.NUM_CH(NUM_CH)) u_req (
    .pend       (pend),
    .ovf_pend   (ovf_pend),
    .irq_ch0    (irq_ch0),
    .irq_shared (irq_shared)
  );

  tiv_clear_ctl #(.NUM_CH(NUM_CH)) u_clr (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_access (vec_access),
    .ack_valid  (ack_valid),
    .ack_line   (ack_line),
    .sel        (sel),
    .any_ch     (any_ch),
    .ovf_pend   (ovf_pend),
    .ch_clear   (ch_clear),
    .ovf_clear  (ovf_clear)
  );

  always_comb begin
    if (any_ch)        code_now = chan_code(idx);
    else if (ovf_pend) code_now = CODE_OVF;
    else               code_now = CODE_NONE;
  end

  assign vec_peek = code_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vec_rdata <= CODE_NONE;
    else if (vec_access) vec_rdata <= code_now;
  end

  assert_rdata_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_access |=> vec_rdata == $past(vec_peek));

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_access |=> $stable(vec_rdata));

  assert_clear_matches_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_access && vec_peek != CODE_NONE && !ovf_clear && vec_peek[0] == 1'b0
     && (ch_clear[NUM_CH-1:1] != '0)) |-> !irq_ch0);

  assert_code_zero_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_peek == CODE_NONE && !irq_ch0) |-> !irq_shared);
endmodule

// File: tb/tiv_vector_top_tb_top.sv
module tiv_vector_top_tb_top;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] ch_flag = '0;
  logic [N-1:0] ch_enable = '0;
  logic ovf_flag = 1'b0;
  logic ovf_enable = 1'b0;
  logic vec_access = 1'b0;
  logic ack_valid = 1'b0;
  logic ack_line = 1'b0;
  logic irq_ch0, irq_shared, ovf_clear;
  logic [3:0] vec_rdata, vec_peek;
  logic [N-1:0] ch_clear;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tiv_vector_top #(.NUM_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_flag(ch_flag), .ch_enable(ch_enable),
    .ovf_flag(ovf_flag), .ovf_enable(ovf_enable), .vec_access(vec_access),
    .ack_valid(ack_valid), .ack_line(ack_line), .irq_ch0(irq_ch0),
    .irq_shared(irq_shared), .vec_rdata(vec_rdata), .vec_peek(vec_peek),
    .ch_clear(ch_clear), .ovf_clear(ovf_clear)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // bench priority model
  function automatic int model_code(logic [N-1:0] f, logic [N-1:0] e, logic of, logic oe);
    for (int i = 0; i < N; i++)
      if (f[i] && e[i]) return 2 * i;
    if (of && oe) return 10;
    return 0;
  endfunction

  task automatic drive(logic [N-1:0] f, logic [N-1:0] e, logic of, logic oe);
    @(negedge clk);
    ch_flag = f; ch_enable = e; ovf_flag = of; ovf_enable = oe;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R12", "rdata in reset", vec_rdata, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R12", "rdata after reset", vec_rdata, 0);
    chk("R12", "idle clears", {ch_clear, ovf_clear}, 0);
    chk("R3", "peek idle", vec_peek, 0);
  endtask

  task automatic t_scan();
    logic [N-1:0] pat [4] = '{5'b10110, 5'b10000, 5'b11111, 5'b01000};
    drive(5'b11111, 5'b00000, 1'b0, 1'b0);
    chk("R1", "flags without enable", vec_peek, 0);
    for (int k = 0; k < 4; k++) begin
      drive(pat[k], 5'b11111, 1'b1, 1'b1);
      chk("R1", "lowest pending wins", vec_peek, model_code(pat[k], 5'b11111, 1'b1, 1'b1));
    end
    drive(5'b11110, 5'b10100, 1'b1, 1'b1);
    chk("R1", "enable masks lower flag", vec_peek, 4);
  endtask

  task automatic t_overflow();
    drive('0, 5'b11111, 1'b1, 1'b1);
    chk("R2", "overflow code", vec_peek, 10);
    drive('0, 5'b11111, 1'b1, 1'b0);
    chk("R3", "overflow disabled", vec_peek, 0);
  endtask

  task automatic access_cycle(string req, int exp_code, logic [N-1:0] exp_clr, logic exp_ovf);
    @(negedge clk); vec_access = 1'b1; #1;
    chk(req, "ch_clear in access cycle", ch_clear, exp_clr);
    chk(req, "ovf_clear in access cycle", ovf_clear, exp_ovf);
    @(posedge clk); #1;
    chk("R7", "rdata after access", vec_rdata, exp_code);
    @(negedge clk); vec_access = 1'b0; #1;
    chk(req, "strobe drops after access", {ch_clear, ovf_clear}, 0);
  endtask

  task automatic t_access_chan();
    drive(5'b01100, 5'b11111, 1'b1, 1'b1);
    access_cycle("R4", 4, 5'b00100, 1'b0);
    drive(5'b01000, 5'b11111, 1'b1, 1'b1);
    access_cycle("R4", 6, 5'b01000, 1'b0);
    repeat (3) @(posedge clk);
    #1 chk("R7", "rdata held", vec_rdata, 6);
  endtask

  task automatic t_access_ch0();
    drive(5'b00011, 5'b11111, 1'b0, 1'b0);
    access_cycle("R5", 0, 5'b00000, 1'b0);
  endtask

  task automatic t_access_ovf();
    drive(5'b00000, 5'b11111, 1'b1, 1'b1);
    access_cycle("R6", 10, 5'b00000, 1'b1);
  endtask

  task automatic t_irq();
    drive(5'b00001, 5'b00001, 1'b0, 1'b0);
    chk("R8", "irq_ch0 set", irq_ch0, 1);
    chk("R9", "irq_shared clear", irq_shared, 0);
    drive(5'b00001, 5'b00000, 1'b0, 1'b0);
    chk("R8", "irq_ch0 masked", irq_ch0, 0);
    drive(5'b10000, 5'b10000, 1'b0, 1'b0);
    chk("R9", "shared by channel 4", irq_shared, 1);
    chk("R8", "ch0 quiet", irq_ch0, 0);
    drive(5'b00000, 5'b00000, 1'b1, 1'b1);
    chk("R9", "shared by overflow", irq_shared, 1);
    drive(5'b00000, 5'b00000, 1'b1, 1'b0);
    chk("R9", "shared quiet", irq_shared, 0);
  endtask

  task automatic t_ack();
    drive(5'b00111, 5'b11111, 1'b1, 1'b1);
    @(negedge clk); ack_valid = 1'b1; ack_line = 1'b0; #1;
    chk("R10", "ack line 0 clears ch0", ch_clear, 5'b00001);
    @(negedge clk); ack_line = 1'b1; #1;
    chk("R11", "ack line 1 clears nothing", {ch_clear, ovf_clear}, 0);
    @(negedge clk); ack_valid = 1'b0; ack_line = 1'b0; #1;
    chk("R12", "idle after ack", {ch_clear, ovf_clear}, 0);
  endtask

  initial begin
    t_reset();
    t_scan();
    t_overflow();
    t_access_chan();
    t_access_ch0();
    t_access_ovf();
    t_irq();
    t_ack();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule